// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is the arithmetic and logic stage of a 32-bit integer datapath. Two register operands and a 16-bit immediate field arrive together with a 4-bit operation code. The block drives the 32-bit result combinationally in the same cycle. It also works out new zero, sign, carry and overflow flags, and stores them in a 4-bit status register on the next rising clock edge, but only when the instruction-valid strobe is high.

The operation set has three arithmetic kinds: add, subtract (second operand minus first) and reverse subtract (first minus second). Add also comes in two immediate forms, one taking a sign-extended 5-bit field and one taking a sign-extended 16-bit field. The bitwise operations OR, AND, XOR and NOT have register forms, and OR, AND and XOR also have zero-extended 16-bit immediate forms. Two address-forming moves add an immediate to the base operand in the second operand position without touching the flags. Each class of operation rewrites its own subset of flags. The surrounding pipeline owns the register file, decode, multiply, divide and shifts.

Top module: `int_alu_flags`

## Requirements
- R1: The status register `flags` holds zero in bit 0, sign in bit 1, carry in bit 2 and overflow in bit 3. A clock edge with `rst` high clears all four bits.
- R2: `flags` changes only on a rising edge where `valid` is high and `rst` is low. `result` is combinational and does not depend on `valid`.
- R3: The add codes are 0 (a+b), 1 (sign-extended imm[4:0] + b) and 2 (sign-extended imm[15:0] + b). Carry is the unsigned carry out. Overflow is set when both addends have the same sign and the result's sign differs from it. Zero and sign follow the result.
- R4: Code 3 computes b - a. Carry is set when b < a unsigned (borrow). Overflow is set when the signs of a and b differ and the result's sign differs from b's. Zero and sign follow the result.
- R5: Code 4 computes a - b. Carry is set when a < b unsigned. Overflow is set when the signs differ and the result's sign differs from a's. Zero and sign follow the result.
- R6: Codes 5 (a|b), 6 (b | zero-extended imm), 7 (a&b), 9 (a^b), 10 (b ^ zero-extended imm) and 11 (~a) update zero and sign, clear overflow and keep carry.
- R7: Code 8 computes b & zero-extended imm. It updates zero, clears sign and overflow, and keeps carry.
- R8: Code 12 computes b + sign-extended imm[15:0]. Code 13 computes b + (imm << 16). Neither changes any flag.
- R9: Codes 14 and 15 are reserved. They drive a result of 0 and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| valid | input | 1 | Instruction valid; enables the flag update |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand / base |
| imm | input | 16 | Immediate field |
| result | output | 32 | Combinational result |
| flags | output | 4 | Registered status {OV, CY, S, Z} |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath, a 5-bit short immediate and a 16-bit long immediate. With these values the sign boundary values 0x7FFFFFFF and 0x80000000, the all-ones word, and the high half produced by the move-high form can all be reached directly. Random operands mixed with these corner values exercise carry and overflow in both subtract directions. Interleaving logic operations with arithmetic shows that carry is kept while overflow is cleared.

// File: rtl/int_alu_flags.sv
module int_alu_flags #(
  parameter int W = 32,
  parameter int SHORT_IMM_W = 5,
  parameter int LONG_IMM_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  valid,
  input  logic [3:0]            op_sel,
  input  logic [W-1:0]          opnd_a,
  input  logic [W-1:0]          opnd_b,
  input  logic [LONG_IMM_W-1:0] imm,
  output logic [W-1:0]          result,
  output logic [3:0]            flags
);
  localparam int MSB = W - 1;
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADDS = 4'd1, OP_ADDL = 4'd2, OP_SUB = 4'd3,
                         OP_RSB = 4'd4, OP_OR = 4'd5, OP_ORI = 4'd6, OP_AND = 4'd7,
                         OP_ANDI = 4'd8, OP_XOR = 4'd9, OP_XORI = 4'd10, OP_NOT = 4'd11,
                         OP_MVA = 4'd12, OP_MVH = 4'd13;
  localparam logic [1:0] CL_NONE = 2'd0, CL_ARITH = 2'd1, CL_LOGIC = 2'd2, CL_ANDI = 2'd3;

  logic [W-1:0] sx_short, sx_long, zx_long, hi_long;
  assign sx_short = {{(W-SHORT_IMM_W){imm[SHORT_IMM_W-1]}}, imm[SHORT_IMM_W-1:0]};
  assign sx_long  = {{(W-LONG_IMM_W){imm[LONG_IMM_W-1]}}, imm};
  assign zx_long  = {{(W-LONG_IMM_W){1'b0}}, imm};
  assign hi_long  = zx_long << LONG_IMM_W;

  logic [W-1:0] add_x, add_y, logic_res;
  logic         add_cin, is_sub, use_adder;
  logic [1:0]   cls;

  always_comb begin
    add_x = opnd_a;
    add_y = opnd_b;
    add_cin = 1'b0;
    is_sub = 1'b0;
    use_adder = 1'b1;
    logic_res = '0;
    cls = CL_NONE;
    case (op_sel)
      OP_ADD:  cls = CL_ARITH;
      OP_ADDS: begin add_x = sx_short; cls = CL_ARITH; end
      OP_ADDL: begin add_x = sx_long;  cls = CL_ARITH; end
      OP_SUB:  begin add_x = opnd_b; add_y = ~opnd_a; add_cin = 1'b1; is_sub = 1'b1; cls = CL_ARITH; end
      OP_RSB:  begin add_y = ~opnd_b; add_cin = 1'b1; is_sub = 1'b1; cls = CL_ARITH; end
      OP_OR:   begin use_adder = 1'b0; logic_res = opnd_a | opnd_b;  cls = CL_LOGIC; end
      OP_ORI:  begin use_adder = 1'b0; logic_res = opnd_b | zx_long; cls = CL_LOGIC; end
      OP_AND:  begin use_adder = 1'b0; logic_res = opnd_a & opnd_b;  cls = CL_LOGIC; end
      OP_ANDI: begin use_adder = 1'b0; logic_res = opnd_b & zx_long; cls = CL_ANDI; end
      OP_XOR:  begin use_adder = 1'b0; logic_res = opnd_a ^ opnd_b;  cls = CL_LOGIC; end
      OP_XORI: begin use_adder = 1'b0; logic_res = opnd_b ^ zx_long; cls = CL_LOGIC; end
      OP_NOT:  begin use_adder = 1'b0; logic_res = ~opnd_a;          cls = CL_LOGIC; end
      OP_MVA:  add_x = sx_long;
      OP_MVH:  add_x = hi_long;
      default: use_adder = 1'b0;
    endcase
  end

  logic [W:0] sum;
  assign sum    = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_cin};
  assign result = use_adder ? sum[MSB:0] : logic_res;

  logic fz, fs, fc, fv;
  assign fz = (result == '0);
  assign fs = result[MSB];
  assign fc = is_sub ? ~sum[W] : sum[W];
  assign fv = (add_x[MSB] == add_y[MSB]) && (sum[MSB] != add_x[MSB]);

  logic [3:0] flags_nx;
  always_comb begin
    case (cls)
      CL_ARITH: flags_nx = {fv, fc, fs, fz};
      CL_LOGIC: flags_nx = {1'b0, flags[2], fs, fz};
      CL_ANDI:  flags_nx = {1'b0, flags[2], 1'b0, fz};
      default:  flags_nx = flags;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= 4'b0;
    else if (valid) flags <= flags_nx;
  end
endmodule

module int_alu_flags_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         valid,
  input logic [3:0]   op_sel,
  input logic [W-1:0] result,
  input logic [3:0]   flags
);
  logic is_logic, is_flagless;
  assign is_logic = (op_sel == 4'd5) || (op_sel == 4'd6) || (op_sel == 4'd7) ||
                    (op_sel == 4'd9) || (op_sel == 4'd10) || (op_sel == 4'd11);
  assign is_flagless = (op_sel >= 4'd12);

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> flags == 4'b0);
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst) !valid |=> $stable(flags));
  a_r3_zero_tracks_result: assert property (@(posedge clk) disable iff (rst)
    (valid && op_sel <= 4'd4) |=> flags[0] == ($past(result) == '0));
  a_r4_sign_tracks_result: assert property (@(posedge clk) disable iff (rst)
    (valid && op_sel <= 4'd4) |=> flags[1] == $past(result[W-1]));
  a_r6_logic_keeps_carry: assert property (@(posedge clk) disable iff (rst)
    (valid && is_logic) |=> (flags[2] == $past(flags[2])) && !flags[3]);
  a_r7_andi_sign_clear: assert property (@(posedge clk) disable iff (rst)
    (valid && op_sel == 4'd8) |=> !flags[1] && !flags[3] && (flags[2] == $past(flags[2])));
  a_r8_moves_keep_flags: assert property (@(posedge clk) disable iff (rst)
    (valid && is_flagless) |=> $stable(flags));
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (op_sel >= 4'd14) |-> result == '0);
endmodule

bind int_alu_flags int_alu_flags_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .valid(valid), .op_sel(op_sel), .result(result), .flags(flags)
);

// File: tb/int_alu_flags_tb_top.sv
module int_alu_flags_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  logic        clk = 1'b0, rst = 1'b1, valid = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [15:0] imm = '0;
  logic [31:0] result;
  logic [3:0]  flags;

  int checks = 0, fails = 0;
  logic [3:0] mflags = '0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu_flags dut_i (.clk(clk), .rst(rst), .valid(valid), .op_sel(op_sel), .opnd_a(opnd_a),
                       .opnd_b(opnd_b), .imm(imm), .result(result), .flags(flags));

  // {op, a, b, imm, expected result}
  localparam logic [115:0] VEC [NVEC] = '{
    {4'd0,  32'h00000001, 32'h00000002, 16'h0000, 32'h00000003},
    {4'd0,  32'hFFFFFFFF, 32'h00000001, 16'h0000, 32'h00000000},
    {4'd0,  32'h7FFFFFFF, 32'h00000001, 16'h0000, 32'h80000000},
    {4'd1,  32'h00000000, 32'h00000005, 16'h001F, 32'h00000004},
    {4'd2,  32'h00000000, 32'h00000000, 16'h8000, 32'hFFFF8000},
    {4'd3,  32'h00000001, 32'h00000000, 16'h0000, 32'hFFFFFFFF},
    {4'd3,  32'h80000000, 32'h00000000, 16'h0000, 32'h80000000},
    {4'd4,  32'h00000005, 32'h00000003, 16'h0000, 32'h00000002},
    {4'd5,  32'h000000F0, 32'h0000000F, 16'h0000, 32'h000000FF},
    {4'd8,  32'h00000000, 32'hFFFF0F0F, 16'hFFFF, 32'h00000F0F},
    {4'd10, 32'h00000000, 32'hFFFFFFFF, 16'h8001, 32'hFFFF7FFE},
    {4'd11, 32'h00000000, 32'h00000000, 16'h0000, 32'hFFFFFFFF},
    {4'd12, 32'h00000000, 32'h00000000, 16'hFFFF, 32'hFFFFFFFF},
    {4'd13, 32'h00000000, 32'h00000001, 16'h1234, 32'h12340001},
    {4'd7,  32'hFFFFFFFF, 32'h80000000, 16'h0000, 32'h80000000},
    {4'd9,  32'h12345678, 32'h12345678, 16'h0000, 32'h00000000},
    {4'd6,  32'h00000000, 32'h00000000, 16'h8000, 32'h00008000},
    {4'd14, 32'h11111111, 32'h22222222, 16'h3333, 32'h00000000}
  };

  function automatic logic [35:0] model(input logic [3:0] op, input logic [31:0] a, b,
                                        input logic [15:0] im, input logic [3:0] pf);
    logic [31:0] r, p, q;
    logic z, s, c, v;
    logic [3:0] nf;
    p = a; q = b; r = '0; c = pf[2]; v = 1'b0; nf = pf;
    if (op == 4'd1) p = {{27{im[4]}}, im[4:0]};
    if (op == 4'd2) p = {{16{im[15]}}, im};
    case (op)
      4'd0, 4'd1, 4'd2: begin
        r = p + q; c = (r < p) || (r < q);
        v = (p[31] == q[31]) && (r[31] != p[31]);
      end
      4'd3: begin r = b - a; c = b < a; v = (a[31] != b[31]) && (r[31] != b[31]); end
      4'd4: begin r = a - b; c = a < b; v = (a[31] != b[31]) && (r[31] != a[31]); end
      4'd5: r = a | b;
      4'd6: r = b | {16'h0, im};
      4'd7: r = a & b;
      4'd8: r = b & {16'h0, im};
      4'd9: r = a ^ b;
      4'd10: r = b ^ {16'h0, im};
      4'd11: r = ~a;
      4'd12: r = b + {{16{im[15]}}, im};
      4'd13: r = b + {im, 16'h0};
      default: r = '0;
    endcase
    z = (r == 0); s = r[31];
    if (op <= 4'd4) nf = {v, c, s, z};
    else if (op == 4'd8) nf = {1'b0, pf[2], 1'b0, z};
    else if (op <= 4'd11) nf = {1'b0, pf[2], s, z};
    return {nf, r};
  endfunction

  function automatic string req_of(input logic [3:0] op);
    if (op <= 4'd2) return "R3";
    if (op == 4'd3) return "R4";
    if (op == 4'd4) return "R5";
    if (op == 4'd8) return "R7";
    if (op <= 4'd11) return "R6";
    if (op <= 4'd13) return "R8";
    return "R9";
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [31:0] a, b, input logic [15:0] im,
                        input logic v, input logic use_exp, input logic [31:0] exp_r);
    logic [35:0] m;
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; imm = im; valid = v;
    m = model(op, a, b, im, mflags);
    #1;
    check(req_of(op), "result", result, use_exp ? exp_r : m[31:0]);
    if (use_exp) check(req_of(op), "model result", m[31:0], exp_r);
    @(posedge clk); #1;
    if (v) mflags = m[35:32];
    check(v ? req_of(op) : "R2", "flags", {28'h0, flags}, {28'h0, mflags});
    valid = 1'b0;
  endtask

  function automatic logic [31:0] pick(input int sel);
    case (sel % 6)
      0: return 32'h00000000;
      1: return 32'h7FFFFFFF;
      2: return 32'h80000000;
      3: return 32'hFFFFFFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "flags after reset", {28'h0, flags}, 32'h0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NVEC; i++)
      run_op(VEC[i][115:112], VEC[i][111:80], VEC[i][79:48], VEC[i][47:32], 1'b1, 1'b1, VEC[i][31:0]);

    // R2: idle strobe must keep flags after a carry+zero add
    run_op(4'd0, 32'hFFFFFFFF, 32'h1, 16'h0, 1'b1, 1'b0, '0);
    run_op(4'd0, 32'h1, 32'h1, 16'h0, 1'b0, 1'b1, 32'h2);
    // R6: carry survives OR, overflow cleared
    run_op(4'd0, 32'h80000000, 32'h80000000, 16'h0, 1'b1, 1'b0, '0);
    run_op(4'd5, 32'h1, 32'h0, 16'h0, 1'b1, 1'b0, '0);
    check("R6", "carry kept", {31'h0, flags[2]}, 32'h1);
    // R4/R5 corner values in both directions
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        run_op(4'd3, pick(i), pick(j), 16'h0, 1'b1, 1'b0, '0);
        run_op(4'd4, pick(i), pick(j), 16'h0, 1'b1, 1'b0, '0);
      end
    // random sweep, every code
    for (int k = 0; k < 400; k++)
      run_op(4'($urandom_range(0, 15)), pick($urandom_range(0, 11)), pick($urandom_range(0, 11)),
             16'($urandom), 1'($urandom_range(0, 3) != 0), 1'b0, '0);
    // R1: reset mid-run
    run_op(4'd0, 32'h7FFFFFFF, 32'h1, 16'h0, 1'b1, 1'b0, '0);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    mflags = '0;
    check("R1", "flags after mid-run reset", {28'h0, flags}, 32'h0);
    @(negedge clk); rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule